// File: doc/BRIEF.md
# Inter-Processor Interrupt and Mailbox Controller

This block gives every core of a small multicore cluster one register bank. The bank holds an interrupt status word, an interrupt enable word and eight 32-bit mailbox slots. Any core can raise an interrupt in another core by writing a 32-bit command that names the target core and a vector number. The controller then sets the bit for that vector in the target's status word. Each core's interrupt line is high while it has a status bit that is also enabled.

Mailbox data moves through a separate 64-bit command. That command carries the target core, a slot number, a 32-bit payload and a 4-bit per-byte keep mask. With an empty mask the payload replaces the slot in one cycle. With a non-empty mask the controller spends one more cycle on a read-merge-write: kept bytes keep their old value and all other bytes take the payload. During that cycle `cmd_ready` is low, so later commands wait and stay in order.

All offsets are byte offsets within the core's register window. The bank of any core can be read through a combinational read port.

Top module: `ipi_mbox_unit`

## Requirements
- R1: After a synchronous active-low reset, every status word, enable word and mailbox slot reads 0, every `irq` bit is 0 and `cmd_ready` is 1.
- R2: A 32-bit write to offset 0x040 is a send-interrupt command. It sets bit `data[4:0]` in the status word of core `data[25:16]`. The status word reads back at offset 0x008 one cycle after acceptance, and bits that were already set stay set.
- R3: A 32-bit write to offset 0x004 loads the issuing core's enable word, which reads back at 0x004. `irq[c]` is high exactly when status and enable of core c share a set bit.
- R4: A 32-bit write to 0x00C ORs the data into the issuing core's status word. A 32-bit write to 0x010 clears every status bit of the issuing core whose data bit is 1.
- R5: A 64-bit write to offset 0x048 is a mailbox send to core `data[25:16]`, slot `data[4:2]`, with payload `data[63:32]`. When the keep mask `data[30:27]` is 0, the payload becomes the whole slot one cycle after acceptance. The slot reads at 0x020 + 4*slot, and `cmd_ready` stays 1.
- R6: When the keep mask is not 0, mask bit i (i = 0 for bits 7:0) set to 1 keeps byte i of the slot and set to 0 takes byte i of the payload. `cmd_ready` is 0 in the cycle after acceptance, and the merged word reads back after that cycle.
- R7: A 64-bit write at any offset other than 0x048, a 32-bit write at 0x048, and 32-bit writes at other offsets (the read-only status offset 0x008 and offsets outside the command set) change no register, mailbox or `irq` output.
- R8: A send-interrupt or mailbox send that names a core index of NCORES or higher changes no register, mailbox or `irq` output.
- R9: A command held valid while `cmd_ready` is 0 is not accepted. It is accepted once ready returns, after the preceding merge has completed, so two merges to the same slot apply in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_wide | input | 1 | 1: 64-bit write, 0: 32-bit write |
| cmd_src | input | 10 | Index of the issuing core (owner of enable/set/clear writes) |
| cmd_addr | input | 12 | Byte offset within the register window |
| cmd_data | input | 64 | Write data; 32-bit writes use bits 31:0 |
| rd_core | input | 10 | Core whose bank is read |
| rd_addr | input | 12 | Read offset |
| rd_data | output | 32 | Read data, 0 for unmapped offsets or absent cores |
| irq | output | NCORES | Per-core interrupt request |

## Verification
The assertions assume that reset is asserted from the first clock edge, that `cmd_valid` is low during reset, and that status and mailboxes change only because of an accepted command or a pending merge. The stimulus drives every command from the falling edge and holds it until it is accepted. It keeps `cmd_valid` low between commands except in the ordering test, where it deliberately holds a second command through the stall cycle.

// File: rtl/ipi_pkg.sv
// Shared constants and types for the inter-processor interrupt and mailbox
// controller. Assumes a 12-bit window offset and 32-bit register words.
package ipi_pkg;
    localparam int WORD_W   = 32;
    localparam int CORE_FW  = 10;
    localparam int NMAIL    = 8;
    localparam int SLOT_W   = 3;
    localparam int KEEP_W   = WORD_W / 8;

    localparam logic [11:0] OFF_ENABLE = 12'h004;
    localparam logic [11:0] OFF_STATUS = 12'h008;
    localparam logic [11:0] OFF_SET    = 12'h00C;
    localparam logic [11:0] OFF_CLEAR  = 12'h010;
    localparam logic [11:0] OFF_MAIL0  = 12'h020;
    localparam logic [11:0] OFF_SEND   = 12'h040;
    localparam logic [11:0] OFF_MSEND  = 12'h048;

    typedef enum logic [2:0] {
        ACT_NONE = 3'd0,
        ACT_EN   = 3'd1,
        ACT_SET  = 3'd2,
        ACT_CLR  = 3'd3,
        ACT_IPI  = 3'd4,
        ACT_MAIL = 3'd5
    } act_e;

    typedef struct packed {
        act_e                act;
        logic [CORE_FW-1:0]  tgt;
        logic [4:0]          vec;
        logic [SLOT_W-1:0]   slot;
        logic [KEEP_W-1:0]   keep;
        logic [WORD_W-1:0]   pay;
        logic [WORD_W-1:0]   wdata;
    } cmd_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
// Command decoder: classifies a write by size and offset and extracts the
// command fields. Pure combinational; assumes 4-byte aligned offsets.
module ipi_cmd_decode
    import ipi_pkg::*;
(
    input  logic        wide,
    input  logic [11:0] addr,
    input  logic [63:0] data,
    output cmd_t        cmd
);
    // Field extraction and size/offset filtering.
    always_comb begin
        cmd       = '0;
        cmd.wdata = data[31:0];
        cmd.tgt   = data[25:16];
        cmd.vec   = data[4:0];
        cmd.slot  = data[4:2];
        cmd.keep  = data[30:27];
        cmd.pay   = data[63:32];
        if (wide) begin
            if (addr == OFF_MSEND) cmd.act = ACT_MAIL;
        end else begin
            unique case (addr)
                OFF_ENABLE: cmd.act = ACT_EN;
                OFF_SET:    cmd.act = ACT_SET;
                OFF_CLEAR:  cmd.act = ACT_CLR;
                OFF_SEND:   cmd.act = ACT_IPI;
                default:    cmd.act = ACT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ipi_byte_merge.sv
// Byte merge: for each byte lane, a set keep bit selects the old byte,
// a clear keep bit selects the new byte. Combinational.
module ipi_byte_merge #(
    parameter int NBYTES = 4
) (
    input  logic [NBYTES-1:0]   keep,
    input  logic [NBYTES*8-1:0] old_w,
    input  logic [NBYTES*8-1:0] new_w,
    output logic [NBYTES*8-1:0] merged
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        // Per-lane select.
        assign merged[b*8 +: 8] = keep[b] ? old_w[b*8 +: 8] : new_w[b*8 +: 8];
    end
endmodule

// File: rtl/ipi_core_bank.sv
// One core's register bank: status, enable and mailbox slots. Assumes the
// caller raises at most one of set/clear/enable/mailbox writes per cycle
// per source, with set applied after clear.
module ipi_core_bank #(
    parameter int NSLOT = 8,
    parameter int WW    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_we,
    input  logic [WW-1:0]          en_d,
    input  logic [WW-1:0]          st_set,
    input  logic [WW-1:0]          st_clr,
    input  logic                   mb_we,
    input  logic [$clog2(NSLOT)-1:0] mb_slot,
    input  logic [WW-1:0]          mb_d,
    output logic [WW-1:0]          status,
    output logic [WW-1:0]          enable,
    output logic [NSLOT*WW-1:0]    mb_flat,
    output logic                   irq
);
    localparam int SW = $clog2(NSLOT);

    // Status and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~st_clr) | st_set;
            if (en_we) enable <= en_d;
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // Mailbox slot register.
        always_ff @(posedge clk) begin
            if (!rst_n) mb_flat[s*WW +: WW] <= '0;
            else if (mb_we && mb_slot == SW'(s)) mb_flat[s*WW +: WW] <= mb_d;
        end
    end

    // Interrupt request from enabled status bits.
    assign irq = |(status & enable);
endmodule

// File: rtl/ipi_mbox_unit.sv
// Top of the inter-processor interrupt and mailbox controller. Accepts one
// command per cycle, stalls one cycle for masked mailbox merges, and offers
// a combinational read port into any core's bank. Assumes aligned offsets.
module ipi_mbox_unit
    import ipi_pkg::*;
#(
    parameter int NCORES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_wide,
    input  logic [9:0]        cmd_src,
    input  logic [11:0]       cmd_addr,
    input  logic [63:0]       cmd_data,
    input  logic [9:0]        rd_core,
    input  logic [11:0]       rd_addr,
    output logic [31:0]       rd_data,
    output logic [NCORES-1:0] irq
);
    localparam int          CIDX_W = (NCORES > 1) ? $clog2(NCORES) : 1;
    localparam int          MB_W   = NMAIL * WORD_W;
    localparam logic [31:0] NC_U   = NCORES;

    cmd_t               dec;
    logic               acc, tgt_ok, src_ok, rd_ok;
    logic [CIDX_W-1:0]  tgt_idx, src_idx, rd_idx;
    logic               pend_v;
    logic [CIDX_W-1:0]  pend_core;
    logic [SLOT_W-1:0]  pend_slot;
    logic [KEEP_W-1:0]  pend_keep;
    logic [WORD_W-1:0]  pend_pay, old_word, merged;

    logic [WORD_W-1:0]  st_set  [NCORES];
    logic [WORD_W-1:0]  st_clr  [NCORES];
    logic               en_we   [NCORES];
    logic               mb_we   [NCORES];
    logic [SLOT_W-1:0]  mb_slot;
    logic [WORD_W-1:0]  mb_d;
    logic [WORD_W-1:0]  status  [NCORES];
    logic [WORD_W-1:0]  enable  [NCORES];
    logic [MB_W-1:0]    mb_all  [NCORES];
    logic [NCORES*WORD_W-1:0] status_flat;
    logic [NCORES*MB_W-1:0]   mail_flat;

    ipi_cmd_decode u_dec (.wide(cmd_wide), .addr(cmd_addr), .data(cmd_data), .cmd(dec));

    // Handshake and range checks.
    assign cmd_ready = ~pend_v;
    assign acc       = cmd_valid & cmd_ready;
    assign tgt_ok    = 32'(dec.tgt) < NC_U;
    assign src_ok    = 32'(cmd_src) < NC_U;
    assign rd_ok     = 32'(rd_core) < NC_U;
    assign tgt_idx   = dec.tgt[CIDX_W-1:0];
    assign src_idx   = cmd_src[CIDX_W-1:0];
    assign rd_idx    = rd_core[CIDX_W-1:0];

    // Pending merge capture; clears itself one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_core <= '0;
            pend_slot <= '0;
            pend_keep <= '0;
            pend_pay  <= '0;
        end else begin
            pend_v <= acc && dec.act == ACT_MAIL && tgt_ok && (dec.keep != '0);
            if (acc) begin
                pend_core <= tgt_idx;
                pend_slot <= dec.slot;
                pend_keep <= dec.keep;
                pend_pay  <= dec.pay;
            end
        end
    end

    // Old word of the slot under merge.
    assign old_word = mb_all[pend_core][32'(pend_slot)*WORD_W +: WORD_W];

    ipi_byte_merge #(.NBYTES(KEEP_W)) u_merge (
        .keep(pend_keep), .old_w(old_word), .new_w(pend_pay), .merged(merged));

    // Per-core write strobes from the accepted command or the pending merge.
    always_comb begin
        for (int c = 0; c < NCORES; c++) begin
            st_set[c] = '0;
            st_clr[c] = '0;
            en_we[c]  = 1'b0;
            mb_we[c]  = 1'b0;
        end
        mb_slot = pend_v ? pend_slot : dec.slot;
        mb_d    = pend_v ? merged : dec.pay;
        if (pend_v) begin
            mb_we[pend_core] = 1'b1;
        end else if (acc) begin
            unique case (dec.act)
                ACT_EN:   if (src_ok) en_we[src_idx] = 1'b1;
                ACT_SET:  if (src_ok) st_set[src_idx] = dec.wdata;
                ACT_CLR:  if (src_ok) st_clr[src_idx] = dec.wdata;
                ACT_IPI:  if (tgt_ok) st_set[tgt_idx] = 32'b1 << dec.vec;
                ACT_MAIL: if (tgt_ok && dec.keep == '0) mb_we[tgt_idx] = 1'b1;
                default:  ;
            endcase
        end
    end

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        ipi_core_bank #(.NSLOT(NMAIL), .WW(WORD_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .en_we(en_we[c]), .en_d(dec.wdata),
            .st_set(st_set[c]), .st_clr(st_clr[c]),
            .mb_we(mb_we[c]), .mb_slot(mb_slot), .mb_d(mb_d),
            .status(status[c]), .enable(enable[c]),
            .mb_flat(mb_all[c]), .irq(irq[c]));
        assign status_flat[c*WORD_W +: WORD_W] = status[c];
        assign mail_flat[c*MB_W +: MB_W]       = mb_all[c];
    end

    // Read port decode.
    always_comb begin
        rd_data = '0;
        if (rd_ok) begin
            if (rd_addr == OFF_ENABLE)      rd_data = enable[rd_idx];
            else if (rd_addr == OFF_STATUS) rd_data = status[rd_idx];
            else if (rd_addr[11:5] == OFF_MAIL0[11:5] && rd_addr[1:0] == 2'b00)
                rd_data = mb_all[rd_idx][32'(rd_addr[4:2])*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/ipi_mbox_unit_chk.sv
// Checker for ipi_mbox_unit: handshake, quiet-state and drop properties.
// Assumes reset is asserted from the first edge and valid is low in reset.
module ipi_mbox_unit_chk
    import ipi_pkg::*;
#(
    parameter int NCORES = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cmd_valid,
    input logic                        cmd_ready,
    input logic                        cmd_wide,
    input logic [11:0]                 cmd_addr,
    input logic [9:0]                  cmd_tgt,
    input logic [3:0]                  cmd_keep,
    input logic [NCORES-1:0]           irq,
    input logic [NCORES*32-1:0]        status_flat,
    input logic [NCORES*NMAIL*32-1:0]  mail_flat,
    input logic                        pend_v
);
    localparam logic [31:0] NC_U = NCORES;
    logic acc, merge_acc;
    assign acc       = cmd_valid && cmd_ready;
    assign merge_acc = acc && cmd_wide && cmd_addr == OFF_MSEND &&
                       32'(cmd_tgt) < NC_U && cmd_keep != 4'b0;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cmd_ready && irq == '0 && status_flat == '0);

    p_irq_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc) |-> $stable(irq));

    p_merge_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        merge_acc |=> !cmd_ready);

    p_mail_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc) && !$past(pend_v) |-> $stable(mail_flat));

    p_wide_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_wide && cmd_addr != OFF_MSEND |=> $stable(mail_flat) && $stable(status_flat));

    p_drop_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !cmd_wide && cmd_addr == OFF_SEND && 32'(cmd_tgt) >= NC_U |=> $stable(status_flat));

    p_stall_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> cmd_ready);
endmodule

bind ipi_mbox_unit ipi_mbox_unit_chk #(.NCORES(NCORES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_wide(cmd_wide), .cmd_addr(cmd_addr), .cmd_tgt(cmd_data[25:16]),
    .cmd_keep(cmd_data[30:27]), .irq(irq), .status_flat(status_flat),
    .mail_flat(mail_flat), .pend_v(pend_v));

// File: tb/ipi_mbox_unit_test.sv
module ipi_mbox_unit_test;
    localparam int N = 4;
    localparam logic [11:0] A_EN = 12'h004, A_ST = 12'h008, A_SET = 12'h00C,
                            A_CLR = 12'h010, A_MB = 12'h020, A_IPI = 12'h040,
                            A_MS = 12'h048;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, cmd_wide = 0;
    logic cmd_ready;
    logic [9:0]  cmd_src = 0, rd_core = 0;
    logic [11:0] cmd_addr = 0, rd_addr = 0;
    logic [63:0] cmd_data = 0;
    logic [31:0] rd_data;
    logic [N-1:0] irq;

    int total = 0, bad = 0;
    bit done = 0;

    logic [31:0] m_st [N];
    logic [31:0] m_en [N];
    logic [31:0] m_mb [N][8];

    typedef struct {
        int          kind;
        int          core;
        logic [11:0] addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    ipi_mbox_unit #(.NCORES(N)) uut (.*);

    always #5 clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per cycle and compares it.
    initial forever begin
        @(negedge clk);
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (it.kind == 0) begin
                rd_core = 10'(it.core);
                rd_addr = it.addr;
                #1 chk(rd_data, it.exp, it.tag);
            end else begin
                #1 chk(32'(irq), it.exp, it.tag);
            end
        end
    end

    task automatic push(input int kind, input int core, input logic [11:0] addr,
                        input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.core = core; it.addr = addr; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    // Pushes the full expected state of every core and the irq vector.
    task automatic expect_all(input string tag);
        logic [31:0] ei;
        ei = '0;
        for (int c = 0; c < N; c++) begin
            push(0, c, A_ST, m_st[c], {tag, " status"});
            push(0, c, A_EN, m_en[c], {tag, " enable"});
            for (int s = 0; s < 8; s++)
                push(0, c, A_MB + 12'(4*s), m_mb[c][s], {tag, " mailbox"});
            ei[c] = |(m_st[c] & m_en[c]);
        end
        push(1, 0, 12'h0, ei, {tag, " irq"});
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    // Driver: offers one command and waits for acceptance.
    task automatic do_cmd(input logic wide, input int src, input logic [11:0] addr,
                          input logic [63:0] data, input logic exp_rdy, input string tag);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_wide = wide; cmd_src = 10'(src);
        cmd_addr = addr; cmd_data = data;
        @(posedge clk);
        #1 cmd_valid = 0;
        chk(32'(cmd_ready), 32'(exp_rdy), {tag, " ready after accept"});
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [63:0] mail_word(input int tgt, input int slot,
                                              input logic [3:0] keep, input logic [31:0] pay);
        logic [63:0] d;
        d = '0;
        d[63:32] = pay; d[30:27] = keep; d[25:16] = 10'(tgt); d[4:2] = 3'(slot);
        return d;
    endfunction

    task automatic w32(input int src, input logic [11:0] off, input logic [31:0] v, input string tag);
        do_cmd(1'b0, src, off, {32'h0, v}, 1'b1, tag);
        if (src < N) begin
            if (off == A_EN)  m_en[src] = v;
            if (off == A_SET) m_st[src] = m_st[src] | v;
            if (off == A_CLR) m_st[src] = m_st[src] & ~v;
        end
        if (off == A_IPI && int'(v[25:16]) < N)
            m_st[v[25:16]] = m_st[v[25:16]] | (32'b1 << v[4:0]);
    endtask

    task automatic mail(input int tgt, input int slot, input logic [3:0] keep,
                        input logic [31:0] pay, input string tag);
        logic ok;
        ok = tgt < N;
        do_cmd(1'b1, 0, A_MS, mail_word(tgt, slot, keep, pay), !(ok && keep != 0), tag);
        if (ok)
            for (int b = 0; b < 4; b++)
                if (!keep[b]) m_mb[tgt][slot][b*8 +: 8] = pay[b*8 +: 8];
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < N; c++) begin
            m_st[c] = 0; m_en[c] = 0;
            for (int s = 0; s < 8; s++) m_mb[c][s] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1: reset state.
        chk(32'(cmd_ready), 32'h1, "R1 ready after reset");
        expect_all("R1 reset");

        // R2/R3: interrupt to an enabled core and to a disabled one.
        w32(1, A_EN, 32'hFFFF_FFFF, "R3 enable core1");
        w32(0, A_IPI, 32'h0001_0005, "R2 ipi core1 v5");
        expect_all("R2 R3 ipi core1");
        w32(0, A_IPI, 32'h0002_001F, "R2 ipi core2 v31");
        w32(3, A_IPI, 32'h0002_0000, "R2 ipi core2 v0");
        expect_all("R2 R3 ipi core2 disabled");

        // R4: set and write-one-to-clear on own status.
        w32(3, A_SET, 32'h0000_00F0, "R4 set core3");
        w32(3, A_CLR, 32'h0000_0030, "R4 clear core3");
        w32(3, A_EN, 32'h0000_0080, "R3 enable core3");
        expect_all("R4 R3 set clear");
        w32(3, A_CLR, 32'hFFFF_FFFF, "R4 clear all core3");
        expect_all("R4 clear irq drop");

        // R5: full-word mailbox writes.
        mail(0, 3, 4'b0000, 32'h1122_3344, "R5 full core0 s3");
        mail(2, 7, 4'b0000, 32'hDEAD_BEEF, "R5 full core2 s7");
        mail(1, 6, 4'b0000, 32'h1122_3344, "R5 full core1 s6");
        expect_all("R5 full writes");

        // R6: masked merges.
        mail(0, 3, 4'b0101, 32'hAABB_CCDD, "R6 merge 0101");
        mail(2, 7, 4'b1111, 32'h0000_0000, "R6 merge keep all");
        mail(2, 0, 4'b1000, 32'h1234_5678, "R6 merge keep top");
        chk(m_mb[0][3], 32'hAA22_CC44, "R6 model sanity");
        expect_all("R6 merges");

        // R7: size and offset filtering.
        do_cmd(1'b1, 0, A_IPI, 64'h0000_0000_0000_0009, 1'b1, "R7 wide at send offset");
        do_cmd(1'b0, 0, A_MS, mail_word(0, 1, 4'b0, 32'h5555_5555), 1'b1, "R7 narrow at mail offset");
        do_cmd(1'b0, 0, 12'h014, 64'hFFFF_FFFF, 1'b1, "R7 unknown offset");
        do_cmd(1'b0, 1, A_ST, 64'hFFFF_FFFF, 1'b1, "R7 status read-only");
        expect_all("R7 ignored");

        // R8: nonexistent target cores.
        w32(0, A_IPI, 32'h0007_0001, "R8 ipi core7");
        w32(0, A_IPI, 32'h03FF_0002, "R8 ipi core1023");
        mail(5, 2, 4'b0000, 32'h7777_7777, "R8 mail core5");
        mail(9, 2, 4'b0011, 32'h7777_7777, "R8 merge core9");
        expect_all("R8 dropped");

        // R9: second command held through the merge stall keeps order.
        @(negedge clk);
        cmd_valid = 1; cmd_wide = 1; cmd_src = 0; cmd_addr = A_MS;
        cmd_data = mail_word(1, 6, 4'b0001, 32'hAABB_CCDD);
        @(posedge clk);
        #1 cmd_data = mail_word(1, 6, 4'b1110, 32'h5566_7788);
        @(negedge clk);
        chk(32'(cmd_ready), 32'h0, "R9 stalled while merging");
        @(posedge clk);
        #1 chk(32'(cmd_ready), 32'h1, "R9 ready returns");
        @(posedge clk);
        #1 cmd_valid = 0;
        repeat (2) @(negedge clk);
        m_mb[1][6] = 32'hAABB_CC88;
        expect_all("R9 ordered merges");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule